// File: doc/BRIEF.md
# Ping-pong stage scheduler

This controller drives a function built as a chain of stages that run strictly one after another on two alternating processing slots. While one slot works on the current stage, the scheduler asks the idle slot to load the configuration for the following stage. Execution and configuration loading both happen outside the block. The scheduler only sees them as request levels and completion pulses.

A job begins with a start pulse that carries a stage count. The scheduler first has slot 0 loaded with stage 0 and waits for that load to complete. It then runs the stages in order. Stage k runs on slot k mod 2, reads from the memory that has that slot's number, and writes to the other memory, so each stage's output becomes the next stage's input. The hand-over to the next stage waits for both the running stage and the pending configuration load to complete, in whichever order they finish. After the last stage a finished flag rises and stays up until the next start.

Top module: `pp_sched`

## Requirements
- R1: A start pulse with a stage count of 0 sets `finished_o` in the next cycle. No run and no configuration request is issued.
- R2: A start pulse with a count n > 0 raises `cfg_req_o` in the next cycle with `cfg_slot_o` = 0 and `cfg_stage_o` = 0. `run_o` stays 0 until `cfg_done_i[0]` is sampled high. Stage 0 starts in the cycle after that.
- R3: Stage k (counted from 0) runs on slot k mod 2. `run_o[slot]` is a level that stays high until that slot's `done_i` bit is sampled. At most one bit of `run_o` is ever high.
- R4: While stage k runs and k < n-1, `cfg_req_o` is high with `cfg_slot_o` set to the other slot and `cfg_stage_o` = k+1. It stays high until `cfg_done_i` of that other slot is sampled.
- R5: While a stage runs on slot s, `src_mem_o` = s and `dst_mem_o` = 1-s.
- R6: Stage k+1 starts exactly one cycle after the later of two events: stage k's done and the configuration done for stage k+1. Between those events no run is active.
- R7: No configuration is requested during the last stage. `finished_o` rises one cycle after the last stage's done is sampled and holds until the next start.
- R8: A `done_i` bit from the slot that is not running is ignored. So is a `cfg_done_i` bit from a slot with no pending request, including bit 1 during the initial load.
- R9: A start pulse that arrives while a job is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted when idle or finished |
| stage_cnt_i | input | IDX_W (4) | Number of stages in the job, sampled with start |
| run_o | output | 2 | Per-slot run request level |
| done_i | input | 2 | Per-slot stage completion pulse |
| cfg_req_o | output | 1 | Configuration load request |
| cfg_slot_o | output | 1 | Slot to be loaded |
| cfg_stage_o | output | IDX_W (4) | Stage index to load |
| cfg_done_i | input | 2 | Per-slot configuration completion pulse |
| src_mem_o | output | 1 | Memory read by the running stage |
| dst_mem_o | output | 1 | Memory written by the running stage |
| finished_o | output | 1 | Job complete; held until the next start |

## Verification
The assertions check several properties on every cycle. At most one slot runs at a time. The slot being loaded is never the slot that is running. The source memory always matches the running slot. A run level stays steady until its own done arrives. The finished flag holds and rises only after a run or a start. The bench scenarios are the only way to show the timing of the hand-over with the two completions in either order or in the same cycle. They also show the immediate finish for a zero count, and that completion pulses from the wrong slot and starts during a job have no effect. Each case is checked cycle by cycle, and a queued scoreboard confirms the order of requests, runs and memory roles.

// File: rtl/pp_sched_pkg.sv
package pp_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2,
    ST_FIN  = 2'd3
  } sched_state_e;

endpackage

// File: rtl/pp_evt_latch.sv
module pp_evt_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic pulse_i,
  output logic seen_o,
  output logic now_o
);

  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seen_q <= 1'b0;
    else if (clr_i) seen_q <= 1'b0;
    else            seen_q <= seen_q | pulse_i;
  end

  assign seen_o = seen_q;
  assign now_o  = seen_q | pulse_i;

  // a recorded completion is kept until the hand-over clears it (R6)
  assert_latch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_o && !clr_i) |=> seen_o);

endmodule

// File: rtl/pp_role_map.sv
module pp_role_map #(
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  input  logic [IDX_W-1:0] cnt_i,
  output logic             run_slot_o,
  output logic             peer_slot_o,
  output logic [IDX_W-1:0] next_idx_o,
  output logic             is_last_o
);

  function automatic logic slot_of(input logic [IDX_W-1:0] idx);
    return idx[0];
  endfunction

  function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] idx);
    return idx + IDX_W'(1);
  endfunction

  function automatic logic last_of(input logic [IDX_W-1:0] idx,
                                   input logic [IDX_W-1:0] cnt);
    return (step_idx(idx) == cnt);
  endfunction

  assign run_slot_o  = slot_of(idx_i);
  assign peer_slot_o = ~slot_of(idx_i);
  assign next_idx_o  = step_idx(idx_i);
  assign is_last_o   = last_of(idx_i, cnt_i);

endmodule

// File: rtl/pp_sched.sv
module pp_sched #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [IDX_W-1:0] stage_cnt_i,
  output logic [1:0]       run_o,
  input  logic [1:0]       done_i,
  output logic             cfg_req_o,
  output logic             cfg_slot_o,
  output logic [IDX_W-1:0] cfg_stage_o,
  input  logic [1:0]       cfg_done_i,
  output logic             src_mem_o,
  output logic             dst_mem_o,
  output logic             finished_o
);
  import pp_sched_pkg::*;

  localparam int NSLOT = 2;

  sched_state_e     state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;

  // named internal events
  logic             run_slot, peer_slot, is_last;
  logic [IDX_W-1:0] next_idx;
  logic             in_run, in_load;
  logic             start_acc;
  logic             exec_pulse, cfg_pulse;
  logic             exec_seen, exec_fin;
  logic             cfg_seen, cfg_now, cfg_fin;
  logic             load_end, stage_end, latch_clr;

  pp_role_map #(.IDX_W(IDX_W)) u_roles (
    .idx_i       (idx_q),
    .cnt_i       (cnt_q),
    .run_slot_o  (run_slot),
    .peer_slot_o (peer_slot),
    .next_idx_o  (next_idx),
    .is_last_o   (is_last)
  );

  assign in_run    = (state_q == ST_RUN);
  assign in_load   = (state_q == ST_LOAD);
  assign start_acc = start_i && (state_q == ST_IDLE || state_q == ST_FIN);

  // only the running slot's done and the pending slot's cfg-done count
  assign exec_pulse = in_run && done_i[run_slot];
  assign cfg_pulse  = in_run ? (cfg_done_i[peer_slot] && !is_last)
                             : (in_load && cfg_done_i[0]);

  assign load_end  = in_load && cfg_pulse;
  assign stage_end = in_run && exec_fin && cfg_fin;
  assign latch_clr = stage_end || start_acc;

  pp_evt_latch u_exec_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (latch_clr),
    .pulse_i (exec_pulse),
    .seen_o  (exec_seen),
    .now_o   (exec_fin)
  );

  pp_evt_latch u_cfg_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (latch_clr || load_end),
    .pulse_i (cfg_pulse && in_run),
    .seen_o  (cfg_seen),
    .now_o   (cfg_now)
  );

  assign cfg_fin = is_last || cfg_now;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE, ST_FIN: begin
        if (start_acc) begin
          cnt_d   = stage_cnt_i;
          idx_d   = '0;
          state_d = (stage_cnt_i == '0) ? ST_FIN : ST_LOAD;
        end
      end
      ST_LOAD: begin
        if (load_end) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (stage_end) begin
          if (is_last) state_d = ST_FIN;
          else         idx_d   = next_idx;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_run
    assign run_o[s] = in_run && (run_slot == 1'(s)) && !exec_seen;
  end

  assign cfg_req_o   = in_load || (in_run && !is_last && !cfg_seen);
  assign cfg_slot_o  = in_load ? 1'b0 : peer_slot;
  assign cfg_stage_o = in_load ? '0 : next_idx;
  assign src_mem_o   = run_slot;
  assign dst_mem_o   = peer_slot;
  assign finished_o  = (state_q == ST_FIN);

  // ---------------- assertions ----------------
  assert_single_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(run_o));

  assert_run_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((run_o != 2'b00) && ((done_i & run_o) == 2'b00)) |=> $stable(run_o));

  assert_cfg_other_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req_o && (run_o != 2'b00)) |-> !run_o[cfg_slot_o]);

  assert_mem_follows_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run_o != 2'b00) |-> (run_o[src_mem_o] && !run_o[dst_mem_o]));

  assert_wait_first_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_load && !cfg_done_i[0]) |=> (run_o == 2'b00));

  assert_finish_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (finished_o && !start_i) |=> finished_o);

  assert_finish_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(finished_o) |-> ($past(run_o) != 2'b00 || $past(start_i)));

endmodule

// File: tb/pp_sched_tb.sv
module pp_sched_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] stage_cnt_i = '0;
  logic [1:0]   done_i = 2'b00;
  logic [1:0]   cfg_done_i = 2'b00;
  logic [1:0]   run_o;
  logic         cfg_req_o, cfg_slot_o, src_mem_o, dst_mem_o, finished_o;
  logic [W-1:0] cfg_stage_o;

  always #4 clk = ~clk;

  pp_sched #(.IDX_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stage_cnt_i(stage_cnt_i),
    .run_o(run_o), .done_i(done_i), .cfg_req_o(cfg_req_o),
    .cfg_slot_o(cfg_slot_o), .cfg_stage_o(cfg_stage_o),
    .cfg_done_i(cfg_done_i), .src_mem_o(src_mem_o), .dst_mem_o(dst_mem_o),
    .finished_o(finished_o)
  );

  // event kinds: 0 config request, 1 run start, 2 finish
  typedef struct packed {
    logic [1:0]   kind;
    logic         slot;
    logic [W-1:0] val;
  } ev_t;

  ev_t exp_q[$];
  int  checks = 0;
  int  errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // ---------------- monitor / scoreboard ----------------
  logic         p_req = 1'b0, p_slot = 1'b0, p_fin = 1'b0;
  logic [W-1:0] p_stage = '0;
  logic [1:0]   p_run = 2'b00;

  task automatic take(input ev_t got);
    ev_t e;
    string tg;
    if (exp_q.size() == 0) begin
      chk(1'b0, "R3 unexpected event", int'(got), -1);
      return;
    end
    e  = exp_q.pop_front();
    tg = (e.kind == 2'd0) ? "R4 config order" :
         (e.kind == 2'd1) ? "R5 run slot/memory order" : "R7 finish order";
    chk(got == e, tg, int'(got), int'(e));
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int s = 0; s < 2; s++)
        if (run_o[s] && !p_run[s])
          take('{kind: 2'd1, slot: 1'(s), val: W'({dst_mem_o, src_mem_o})});
      if (cfg_req_o && !(p_req && p_slot == cfg_slot_o && p_stage == cfg_stage_o))
        take('{kind: 2'd0, slot: cfg_slot_o, val: cfg_stage_o});
      if (finished_o && !p_fin)
        take('{kind: 2'd2, slot: 1'b0, val: '0});
      p_req   <= cfg_req_o;
      p_slot  <= cfg_slot_o;
      p_stage <= cfg_stage_o;
      p_run   <= run_o;
      p_fin   <= finished_o;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    summary();
  end

  // ---------------- driver ----------------
  // mode bit0: wrong-slot pulses (R8); bit1: start while busy (R9)
  task automatic job(input int n, input int mode);
    bit    noise = mode[0];
    bit    busy  = mode[1];
    string tg    = noise ? "R8" : (busy ? "R9" : "R3");
    int    dl    = mode + 1;

    if (n == 0) exp_q.push_back('{kind: 2'd2, slot: 1'b0, val: '0});
    else begin
      exp_q.push_back('{kind: 2'd0, slot: 1'b0, val: '0});
      for (int k = 0; k < n; k++) begin
        exp_q.push_back('{kind: 2'd1, slot: 1'(k % 2), val: W'({1'(~k[0]), 1'(k[0])})});
        if (k < n - 1)
          exp_q.push_back('{kind: 2'd0, slot: 1'(~k[0]), val: W'(k + 1)});
      end
      exp_q.push_back('{kind: 2'd2, slot: 1'b0, val: '0});
    end

    @(negedge clk);
    start_i = 1'b1; stage_cnt_i = W'(n);
    @(negedge clk);
    start_i = 1'b0; stage_cnt_i = W'(5);

    if (n == 0) begin
      chk(finished_o == 1'b1, "R1 finished after zero count", int'(finished_o), 1);
      chk(run_o == 2'b00 && !cfg_req_o, "R1 no run or config", int'({run_o, cfg_req_o}), 0);
    end else begin
      for (int t = 0; t <= dl; t++) begin
        chk(cfg_req_o && !cfg_slot_o && cfg_stage_o == '0, "R2 initial load request",
            int'({cfg_req_o, cfg_slot_o, cfg_stage_o}), 16 * 2);
        chk(run_o == 2'b00, "R2 no run before load done", int'(run_o), 0);
        cfg_done_i = (t == dl) ? 2'b01 : ((noise && t % 2 == 0) ? 2'b10 : 2'b00);
        done_i     = (noise && t < dl) ? 2'b01 : 2'b00;
        @(negedge clk);
      end
      cfg_done_i = 2'b00; done_i = 2'b00;

      for (int k = 0; k < n; k++) begin
        bit s    = k[0];
        bit last = (k == n - 1);
        int de   = (k * 3 + mode) % 4;
        int dc   = (k * 2 + 1 + mode) % 5;
        int tm   = last ? de : ((de > dc) ? de : dc);
        if (k > 0)
          chk(run_o == (2'b01 << s), "R6 next stage one cycle after both", int'(run_o),
              int'(2'b01 << s));
        for (int t = 0; t <= tm; t++) begin
          logic [1:0] er = (t <= de) ? (2'b01 << s) : 2'b00;
          bit         ec = !last && (t <= dc);
          chk(run_o == er, {tg, " run level timing"}, int'(run_o), int'(er));
          chk(cfg_req_o == ec, last ? "R7 no config in last stage" : "R4 config request window",
              int'(cfg_req_o), int'(ec));
          if (cfg_req_o)
            chk(cfg_slot_o == !s && cfg_stage_o == W'(k + 1), "R4 config target",
                int'({cfg_slot_o, cfg_stage_o}), int'({!s, 4'(k + 1)}));
          chk(src_mem_o == s && dst_mem_o == !s, "R5 memory roles",
              int'({src_mem_o, dst_mem_o}), int'({s, !s}));
          done_i[s]      = (t == de);
          done_i[!s]     = noise && (t % 2 == 0);
          cfg_done_i[!s] = !last && (t == dc);
          cfg_done_i[s]  = noise;
          start_i        = busy && (t == 0);
          stage_cnt_i    = busy ? W'(0) : W'(5);
          @(negedge clk);
        end
        done_i = 2'b00; cfg_done_i = 2'b00; start_i = 1'b0;
      end
      chk(finished_o == 1'b1, "R7 finished one cycle after last done", int'(finished_o), 1);
      chk(run_o == 2'b00, "R7 no run after last stage", int'(run_o), 0);
    end

    for (int h = 0; h < 3; h++) begin
      @(negedge clk);
      chk(finished_o == 1'b1 && !cfg_req_o && run_o == 2'b00, "R7 finished holds",
          int'({finished_o, cfg_req_o, run_o}), 8);
    end
    chk(exp_q.size() == 0, "R3 all expected events observed", exp_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(run_o == 2'b00 && !cfg_req_o && !finished_o, "reset state",
        int'({run_o, cfg_req_o, finished_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(run_o == 2'b00 && !cfg_req_o && !finished_o, "idle after reset",
        int'({run_o, cfg_req_o, finished_o}), 0);

    job(0, 0);   // R1 zero count
    job(1, 0);   // single stage, no config request
    job(3, 0);   // mixed completion orders
    job(4, 1);   // R8 wrong-slot pulses
    job(5, 2);   // R9 start while busy
    job(15, 3);  // longest job with both disturbances
    job(2, 0);   // restart from finished

    repeat (2) @(negedge clk);
    summary();
  end

endmodule